// File: doc/BRIEF.md
# Rotation-Invariant Cellular Automaton Array

This block holds a square field of one-bit cells and advances the whole field by one generation whenever it is asked to. A cell's next value depends only on a five-cell neighbourhood: the cell itself and its north, east, south and west neighbours. Up to three programmable patterns are compared against that neighbourhood. Each pattern counts in all four quarter-turn orientations. When any active pattern in any orientation matches, the cell inverts. When nothing matches, the cell keeps its value. The rule is a pattern match, not a neighbour count.

Software, or a controller around the block, first programs the patterns. It then writes a starting configuration one row at a time and pulses the step input as many times as needed, reading rows back at any point. A free-running generation counter records how many steps have been taken since reset. With a suitable pattern set, the array can carry moving signals along bands of cells. Building such structures belongs to the user and is not done by the block.

Top module: `ca_array`

## Requirements
- R1: After reset every cell reads 0, the generation count reads 0 and no pattern is active, so a step leaves any loaded field unchanged.
- R2: A pattern write with index 0, 1 or 2 stores the 5-bit pattern in that slot and makes it active. A write with index 3 changes nothing. Pattern bit 4 is the centre, bit 3 north, bit 2 east, bit 1 south and bit 0 west.
- R3: A pattern matches a cell when the neighbourhood equals the pattern or one of its three quarter-turn rotations. A rotation keeps the centre and moves the four neighbour bits cyclically around it.
- R4: On a step, a cell with at least one match inverts, and a cell with no match keeps its value.
- R5: While step and load are both low, every cell and the generation count stay unchanged.
- R6: All cells update on the same edge, and each uses the values its neighbours had before that step.
- R7: Neighbours outside the field read as 0. Row data bit c is column c. Column c+1 is east, column c-1 is west, row r-1 is north and row r+1 is south.
- R8: A load writes the given 32-bit data into the addressed row. When load and step are high in the same cycle, only the load happens: no other row changes and the count does not advance.
- R9: Each accepted step increases the generation count by exactly one, modulo 2^16.
- R10: The read port combinationally shows the current contents of the row selected by the read address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pat_we | input | 1 | Pattern write strobe |
| pat_idx | input | 2 | Pattern slot index (3 is ignored) |
| pat_val | input | 5 | Pattern {centre, north, east, south, west} |
| load_en | input | 1 | Row load strobe, takes priority over step |
| load_row | input | 5 | Row address for loading |
| load_bits | input | 32 | Row data for loading |
| step_en | input | 1 | Advance the field by one generation |
| rd_row | input | 5 | Row address for readout |
| rd_bits | output | 32 | Current contents of the selected row |
| gen_count | output | 16 | Generations taken since reset |

## Verification
The embedded assertions check on every cycle that an idle cycle freezes the field and the count, that a step XORs the field with the per-cell match vector and adds one to the count, that a load writes its row and stops the step, and that a write to slot 3 leaves the pattern store alone. Which cells should match depends on the whole field and the rotation semantics, so only the bench can show it. The bench does this by comparing every row with an independent model after each step, across several pattern sets and pseudo-random fields. It also runs a hand-worked edge case in which a full field loses exactly its non-corner border cells.

// File: rtl/ca_pkg.sv
package ca_pkg;
  localparam int unsigned CA_ROWS   = 32;
  localparam int unsigned CA_COLS   = 32;
  localparam int unsigned CA_RULES  = 3;
  localparam int unsigned CA_PAT_W  = 5;
  localparam int unsigned CA_GEN_W  = 16;
  localparam int unsigned CA_IDX_W  = 2;

  // neighbourhood bit positions
  localparam int unsigned B_CTR = 4;
  localparam int unsigned B_N   = 3;
  localparam int unsigned B_E   = 2;
  localparam int unsigned B_S   = 1;
  localparam int unsigned B_W   = 0;

  typedef logic [CA_PAT_W-1:0] nbhd_t;

  // quarter turn clockwise applied k times: north value moves to east, etc.
  function automatic nbhd_t turn_cw(nbhd_t p, int unsigned k);
    nbhd_t t;
    t = p;
    for (int unsigned i = 0; i < 4; i++) begin
      if (i < k) t = {t[B_CTR], t[B_W], t[B_N], t[B_E], t[B_S]};
    end
    return t;
  endfunction
endpackage

// File: rtl/ca_rule_bank.sv
module ca_rule_bank #(
  parameter int unsigned NRULES = 3,
  parameter int unsigned PAT_W  = 5,
  parameter int unsigned IDX_W  = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [IDX_W-1:0]             idx,
  input  logic [PAT_W-1:0]             pat,
  output logic [NRULES-1:0][PAT_W-1:0] pats_q,
  output logic [NRULES-1:0]            live_q
);
  logic [NRULES-1:0][PAT_W-1:0] pats_d;
  logic [NRULES-1:0]            live_d;
  logic [NRULES-1:0]            sel;

  for (genvar k = 0; k < NRULES; k++) begin : g_slot
    assign sel[k] = we && (idx == IDX_W'(k));

    always_comb begin
      pats_d[k] = pats_q[k];
      live_d[k] = live_q[k];
      if (sel[k]) begin
        pats_d[k] = pat;
        live_d[k] = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pats_q[k] <= '0;
        live_q[k] <= 1'b0;
      end else if (sel[k]) begin
        pats_q[k] <= pats_d[k];
        live_q[k] <= live_d[k];
      end
    end
  end

  AST_SLOT3_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (int'(idx) >= int'(NRULES))) |=> ($stable(pats_q) && $stable(live_q))); // R2
endmodule

// File: rtl/ca_cell_match.sv
module ca_cell_match
  import ca_pkg::*;
#(
  parameter int unsigned NRULES = 3
) (
  input  nbhd_t                        nbhd,
  input  logic [NRULES-1:0][CA_PAT_W-1:0] pats,
  input  logic [NRULES-1:0]            live,
  output logic                         hit
);
  logic [NRULES-1:0][3:0] rot_hit;

  for (genvar k = 0; k < NRULES; k++) begin : g_rule
    for (genvar r = 0; r < 4; r++) begin : g_rot
      assign rot_hit[k][r] = live[k] && (nbhd == turn_cw(pats[k], r));
    end
  end

  assign hit = |rot_hit;
endmodule

// File: rtl/ca_grid.sv
module ca_grid
  import ca_pkg::*;
#(
  parameter int unsigned ROWS   = 32,
  parameter int unsigned COLS   = 32,
  parameter int unsigned NRULES = 3,
  parameter int unsigned GEN_W  = 16,
  localparam int unsigned AW    = $clog2(ROWS)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            step_en,
  input  logic                            load_en,
  input  logic [AW-1:0]                   load_row,
  input  logic [COLS-1:0]                 load_bits,
  input  logic [AW-1:0]                   rd_row,
  output logic [COLS-1:0]                 rd_bits,
  input  logic [NRULES-1:0][CA_PAT_W-1:0] pats,
  input  logic [NRULES-1:0]               live,
  output logic [GEN_W-1:0]                gen_q
);
  logic [ROWS-1:0][COLS-1:0]     cells_q, cells_d;
  logic [ROWS-1:0][COLS-1:0]     flip;
  logic [ROWS+1:0][COLS+1:0]     pad;
  logic [GEN_W-1:0]              gen_d;
  logic                          adv, upd;

  // zero border around the field
  always_comb begin
    pad = '0;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        pad[r+1][c+1] = cells_q[r][c];
      end
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      nbhd_t nb;
      assign nb = {pad[r+1][c+1], pad[r][c+1], pad[r+1][c+2],
                   pad[r+2][c+1], pad[r+1][c]};
      ca_cell_match #(.NRULES(NRULES)) u_match (
        .nbhd (nb),
        .pats (pats),
        .live (live),
        .hit  (flip[r][c])
      );
    end
  end

  assign adv = step_en && !load_en;
  assign upd = step_en || load_en;

  always_comb begin
    cells_d = cells_q;
    gen_d   = gen_q;
    if (load_en) begin
      cells_d[load_row] = load_bits;
    end else if (step_en) begin
      cells_d = cells_q ^ flip;
      gen_d   = gen_q + GEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cells_q <= '0;
      gen_q   <= '0;
    end else if (upd) begin
      cells_q <= cells_d;
      gen_q   <= gen_d;
    end
  end

  assign rd_bits = cells_q[rd_row];

  AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_en && !load_en) |=> ($stable(cells_q) && $stable(gen_q))); // R5
  AST_STEP_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (cells_q == ($past(cells_q) ^ $past(flip)))); // R4
  AST_GEN_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (gen_q == GEN_W'($past(gen_q) + GEN_W'(1)))); // R9
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> ($stable(gen_q) && (cells_q[$past(load_row)] == $past(load_bits)))); // R8
endmodule

// File: rtl/ca_array.sv
module ca_array
  import ca_pkg::*;
#(
  parameter int unsigned ROWS   = CA_ROWS,
  parameter int unsigned COLS   = CA_COLS,
  parameter int unsigned NRULES = CA_RULES,
  parameter int unsigned GEN_W  = CA_GEN_W,
  localparam int unsigned AW    = $clog2(ROWS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pat_we,
  input  logic [CA_IDX_W-1:0] pat_idx,
  input  logic [CA_PAT_W-1:0] pat_val,
  input  logic                load_en,
  input  logic [AW-1:0]       load_row,
  input  logic [COLS-1:0]     load_bits,
  input  logic                step_en,
  input  logic [AW-1:0]       rd_row,
  output logic [COLS-1:0]     rd_bits,
  output logic [GEN_W-1:0]    gen_count
);
  logic [1:0]                     rst_pipe;
  logic                           rst_in_n;
  logic [NRULES-1:0][CA_PAT_W-1:0] pats;
  logic [NRULES-1:0]              live;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_in_n = rst_pipe[1];

  ca_rule_bank #(.NRULES(NRULES), .PAT_W(CA_PAT_W), .IDX_W(CA_IDX_W)) u_rules (
    .clk    (clk),
    .rst_n  (rst_in_n),
    .we     (pat_we),
    .idx    (pat_idx),
    .pat    (pat_val),
    .pats_q (pats),
    .live_q (live)
  );

  ca_grid #(.ROWS(ROWS), .COLS(COLS), .NRULES(NRULES), .GEN_W(GEN_W)) u_grid (
    .clk       (clk),
    .rst_n     (rst_in_n),
    .step_en   (step_en),
    .load_en   (load_en),
    .load_row  (load_row),
    .load_bits (load_bits),
    .rd_row    (rd_row),
    .rd_bits   (rd_bits),
    .pats      (pats),
    .live      (live),
    .gen_q     (gen_count)
  );
endmodule

// File: tb/ca_array_tb.sv
`timescale 1ns/1ps
module ca_array_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        pat_we;
  logic [1:0]  pat_idx;
  logic [4:0]  pat_val;
  logic        load_en;
  logic [4:0]  load_row;
  logic [31:0] load_bits;
  logic        step_en;
  logic [4:0]  rd_row;
  logic [31:0] rd_bits;
  logic [15:0] gen_count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m [32];
  logic [4:0]  mr [3];
  logic        mv [3];
  logic [15:0] mgen;

  // {rule0, rule1, rule2, seed, steps}
  localparam logic [54:0] VEC [6] = '{
    {5'b10000, 5'b01000, 5'b11100, 32'h1234_5678, 8'd3},
    {5'b01011, 5'b10100, 5'b00110, 32'hDEAD_BEEF, 8'd4},
    {5'b11111, 5'b00000, 5'b10001, 32'h0F0F_1357, 8'd2},
    {5'b01111, 5'b10111, 5'b00011, 32'hA5A5_0001, 8'd5},
    {5'b11000, 5'b01100, 5'b10010, 32'h7777_3333, 8'd3},
    {5'b00001, 5'b11101, 5'b01010, 32'hC001_D00D, 8'd4}
  };

  ca_array u_dut (
    .clk(clk), .rst_n(rst_n), .pat_we(pat_we), .pat_idx(pat_idx), .pat_val(pat_val),
    .load_en(load_en), .load_row(load_row), .load_bits(load_bits), .step_en(step_en),
    .rd_row(rd_row), .rd_bits(rd_bits), .gen_count(gen_count)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic mget(int r, int c);
    if (r < 0 || r > 31 || c < 0 || c > 31) return 1'b0;
    return m[r][c];
  endfunction

  function automatic logic [31:0] xs(logic [31:0] s);
    logic [31:0] t;
    t = s ^ (s << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  task automatic model_step();
    logic [31:0] nx [32];
    for (int r = 0; r < 32; r++) begin
      for (int c = 0; c < 32; c++) begin
        logic [4:0] o;
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < 3; k++) begin
          o = {mget(r,c), mget(r-1,c), mget(r,c+1), mget(r+1,c), mget(r,c-1)};
          for (int q = 0; q < 4; q++) begin
            if (mv[k] && o == mr[k]) hit = 1'b1;
            o = {o[4], o[2:0], o[3]};
          end
        end
        nx[r][c] = m[r][c] ^ hit;
      end
    end
    for (int r = 0; r < 32; r++) m[r] = nx[r];
    mgen = mgen + 16'd1;
  endtask

  task automatic write_rule(int k, logic [4:0] p);
    @(negedge clk);
    pat_we = 1'b1; pat_idx = 2'(k); pat_val = p;
    @(negedge clk);
    pat_we = 1'b0;
    if (k < 3) begin mr[k] = p; mv[k] = 1'b1; end
  endtask

  task automatic load(int a, logic [31:0] d);
    @(negedge clk);
    load_en = 1'b1; load_row = 5'(a); load_bits = d;
    @(negedge clk);
    load_en = 1'b0;
    m[a] = d;
  endtask

  task automatic step();
    @(negedge clk);
    step_en = 1'b1;
    @(negedge clk);
    step_en = 1'b0;
    model_step();
  endtask

  task automatic check_all(string req);
    for (int r = 0; r < 32; r++) begin
      rd_row = 5'(r);
      #0.2;
      chk(req, rd_bits, m[r]);
    end
    chk(req, 32'(gen_count), 32'(mgen));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pat_we = 0; pat_idx = 0; pat_val = 0;
    load_en = 0; load_row = 0; load_bits = 0; step_en = 0; rd_row = 0;
    for (int r = 0; r < 32; r++) m[r] = '0;
    for (int k = 0; k < 3; k++) begin mr[k] = '0; mv[k] = 1'b0; end
    mgen = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R10: reset state visible through the read port
    check_all("R1 R10 reset");

    // R1: no pattern active after reset, a step holds the field
    load(3, 32'h0000_0100);
    load(10, 32'h8000_0001);
    step();
    check_all("R1 no active pattern");

    // R2: slot 3 write is ignored (pattern would kill isolated ones)
    write_rule(3, 5'b10000);
    step();
    check_all("R2 slot3 ignored");

    // R2 R4: slot 0 write takes effect, isolated ones vanish
    write_rule(0, 5'b10000);
    step();
    chk("R2 R4 isolated cleared", 32'(m[3]), 32'h0);
    check_all("R2 R4 after write");

    // R7 R3: full field, pattern centre 1 with north 0 and others 1
    write_rule(0, 5'b10111);
    write_rule(1, 5'b10111);
    write_rule(2, 5'b10111);
    for (int r = 0; r < 32; r++) load(r, 32'hFFFF_FFFF);
    step();
    rd_row = 5'd0;  #0.2; chk("R7 top row edge", rd_bits, 32'h8000_0001);
    rd_row = 5'd31; #0.2; chk("R7 bottom row edge", rd_bits, 32'h8000_0001);
    rd_row = 5'd15; #0.2; chk("R3 rotated side edges", rd_bits, 32'h7FFF_FFFE);
    check_all("R7 R3 model");

    // R5: idle cycles hold field and count
    repeat (6) @(negedge clk);
    check_all("R5 idle hold");

    // R8: load and step together, only the load happens
    @(negedge clk);
    load_en = 1'b1; step_en = 1'b1; load_row = 5'd7; load_bits = 32'h1357_9BDF;
    @(negedge clk);
    load_en = 1'b0; step_en = 1'b0;
    m[7] = 32'h1357_9BDF;
    check_all("R8 load over step");

    // R6 R4 R9: table of pattern sets and pseudo-random fields
    foreach (VEC[i]) begin
      logic [31:0] s;
      write_rule(0, VEC[i][54:50]);
      write_rule(1, VEC[i][49:45]);
      write_rule(2, VEC[i][44:40]);
      s = VEC[i][39:8];
      for (int r = 0; r < 32; r++) begin
        s = xs(s);
        load(r, (i % 2 == 0) ? s : (s & xs(s ^ 32'h5A5A_A5A5)));
      end
      for (int n = 0; n < int'(VEC[i][7:0]); n++) begin
        step();
        check_all("R6 R4 R9 table");
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule